// File: doc/BRIEF.md
# Address-Aligned Transaction Packet Beat Packer

This block turns a transaction layer request into a stream of 64-bit beats for a transmit interface. Each beat carries two dwords: the earlier dword in the lower half (bits 31:0), the later one in the upper half (bits 63:32). A command transfer supplies the header (three or four dwords), a flag for the four-dword form, address bit 2 of the request, and the payload length. The payload follows on a separate stream, two dwords per transfer.

Where the first payload dword lands is set by address bit 2, not by the header length. When bit 2 is 0 the first payload dword is placed in a lower half. When bit 2 is 1 it is placed in an upper half. A zero filler dword is inserted after the header whenever the header length alone would put it in the wrong half. The first beat is flagged start-of-packet and the beat holding the last payload dword is flagged end-of-packet.

The output uses a valid/ready handshake, and backpressure propagates to both input channels. A new packet can follow the previous one with no idle cycle.

Top module: `tlp_packer`

## Requirements
- R1: The first beat of each packet has tx_sop_o=1 and carries header dword 0 in the lower half and dword 1 in the upper half. The command is accepted on the same handshake. No later beat of the packet has tx_sop_o set.
- R2: With a three-dword header and address bit 2 = 1, the second beat is {payload 0 (upper), header dword 2 (lower)}. No filler is inserted.
- R3: With a three-dword header and address bit 2 = 0, the second beat is {zero filler (upper), header dword 2 (lower)}. The third beat starts with payload 0 in the lower half.
- R4: With a four-dword header and address bit 2 = 0, the second beat is {header dword 3, header dword 2}. The third beat is {payload 1, payload 0}.
- R5: With a four-dword header and address bit 2 = 1, the third beat is {payload 0 (upper), zero filler (lower)}.
- R6: tx_eop_o is set only on the beat holding the last payload dword. If that dword is in the lower half, the upper half is zero, even when the input carried other data there. A packet spans ceil((P+N)/2) beats, where P is the dword position of payload 0 and N is the length.
- R7: The length field counts dwords. A code of 0 means 1024 dwords.
- R8: While tx_valid_o=1 and tx_ready_i=0, the next cycle still presents the same data, SOP and EOP with tx_valid_o=1. cmd_ready_o and pld_ready_o are 0 whenever tx_ready_i=0.
- R9: After an EOP beat is accepted, the next cycle presents the next packet's SOP beat if a command is valid.
- R10: After reset, with no command valid, tx_valid_o=0 and pld_ready_o=0.
- R11: Payload input is taken lower dword first, exactly ceil(N/2) transfers per packet. The upper half of the final transfer is ignored when N is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command accepted when both are high |
| cmd_hdr_i | input | 4*DW | Header dwords, dword j at bits [32j+31:32j] |
| cmd_hdr4_i | input | 1 | 1: four-dword header, 0: three-dword header |
| cmd_addr2_i | input | 1 | Request address bit 2 |
| cmd_len_i | input | LEN_W | Payload length in dwords, 0 means 1024 |
| pld_valid_i | input | 1 | Payload transfer valid |
| pld_ready_o | output | 1 | Payload transfer accepted when both are high |
| pld_data_i | input | 2*DW | Two payload dwords, earlier in the lower half |
| tx_valid_o | output | 1 | Output beat valid |
| tx_ready_i | input | 1 | Downstream ready |
| tx_data_o | output | 2*DW | Output beat |
| tx_sop_o | output | 1 | First beat of a packet |
| tx_eop_o | output | 1 | Beat holding the last payload dword |

## Verification
The hold property assumes that both sources keep valid and data steady until their transfer is taken, because the first beat is taken straight from the command port and payload beats from the payload port. The bench only changes a command or payload transfer once it has been accepted. It only inserts payload gaps while nothing is pending. Stalls are driven on tx_ready_i at fixed cycle phases while the length, alignment and header form are varied. The unused upper payload dwords carry a marker value, so any leak into the output is visible.

// File: rtl/tlp_pack_pkg.sv
package tlp_pack_pkg;
  // beat currently presented
  typedef enum logic [2:0] {
    ST_H0    = 3'd0, // header dwords 0/1, from command port
    ST_H1    = 3'd1, // header dword 2 (+3 or filler)
    ST_ODD   = 3'd2, // payload 0 in upper slot
    ST_EVEN  = 3'd3, // payload passes through unshifted
    ST_SHIFT = 3'd4, // carry in lower, new dword in upper
    ST_TAIL  = 3'd5  // carry in lower, filler in upper
  } pack_st_e;

  function automatic logic is_pld_st(pack_st_e s);
    return (s == ST_ODD) || (s == ST_EVEN) || (s == ST_SHIFT);
  endfunction
endpackage

// File: rtl/tlp_pack_ctrl.sv
module tlp_pack_ctrl
  import tlp_pack_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic             cmd_hdr4_i,
  input  logic             cmd_addr2_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic             addr2_q_i,
  input  logic             pld_valid_i,
  input  logic             tx_ready_i,
  output pack_st_e         st_o,
  output logic             cmd_ready_o,
  output logic             pld_ready_o,
  output logic             tx_valid_o,
  output logic             tx_sop_o,
  output logic             tx_eop_o,
  output logic             last_lo_o,
  output logic             cmd_take_o,
  output logic             carry_take_o
);
  localparam int REM_W = LEN_W + 1;
  localparam logic [REM_W-1:0] LEN_MAX = {1'b1, {LEN_W{1'b0}}};

  pack_st_e         st_q, st_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [REM_W-1:0] len_dec;
  logic             fire;

  assign len_dec = (cmd_len_i == '0) ? LEN_MAX : REM_W'(cmd_len_i);

  always_comb begin
    tx_valid_o = 1'b0;
    tx_eop_o   = 1'b0;
    unique case (st_q)
      ST_H0:    tx_valid_o = cmd_valid_i;
      ST_H1:    tx_valid_o = 1'b1;
      ST_ODD: begin
        tx_valid_o = pld_valid_i;
        tx_eop_o   = (rem_q == REM_W'(1));
      end
      ST_EVEN: begin
        tx_valid_o = pld_valid_i;
        tx_eop_o   = (rem_q <= REM_W'(2));
      end
      ST_SHIFT: begin
        tx_valid_o = pld_valid_i;
        tx_eop_o   = (rem_q == REM_W'(2));
      end
      ST_TAIL: begin
        tx_valid_o = 1'b1;
        tx_eop_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign tx_sop_o     = (st_q == ST_H0);
  assign cmd_ready_o  = tx_ready_i && (st_q == ST_H0);
  assign pld_ready_o  = tx_ready_i && is_pld_st(st_q);
  assign fire         = tx_valid_o && tx_ready_i;
  assign cmd_take_o   = fire && (st_q == ST_H0);
  assign carry_take_o = fire && ((st_q == ST_ODD) || (st_q == ST_SHIFT));
  assign last_lo_o    = (st_q == ST_EVEN) && (rem_q == REM_W'(1));
  assign st_o         = st_q;

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    if (fire) begin
      unique case (st_q)
        ST_H0: begin
          rem_d = len_dec;
          st_d  = (!cmd_hdr4_i && cmd_addr2_i) ? ST_ODD : ST_H1;
        end
        ST_H1: st_d = addr2_q_i ? ST_ODD : ST_EVEN;
        ST_ODD: begin
          rem_d = rem_q - REM_W'(1);
          if (rem_q == REM_W'(1))      st_d = ST_H0;
          else if (rem_q == REM_W'(2)) st_d = ST_TAIL;
          else                         st_d = ST_SHIFT;
        end
        ST_EVEN: begin
          rem_d = rem_q - REM_W'(2);
          if (rem_q <= REM_W'(2)) st_d = ST_H0;
        end
        ST_SHIFT: begin
          rem_d = rem_q - REM_W'(2);
          if (rem_q == REM_W'(2))      st_d = ST_H0;
          else if (rem_q == REM_W'(3)) st_d = ST_TAIL;
        end
        ST_TAIL: st_d = ST_H0;
        default: st_d = ST_H0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_H0;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/tlp_pack_store.sv
module tlp_pack_store #(
  parameter int DW     = 32,
  parameter int HI_CNT = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_take_i,
  input  logic [HI_CNT*DW-1:0]      cmd_hdr_hi_i,
  input  logic                      cmd_hdr4_i,
  input  logic                      cmd_addr2_i,
  input  logic                      carry_take_i,
  input  logic [DW-1:0]             carry_d_i,
  output logic [HI_CNT-1:0][DW-1:0] hdr_q_o,
  output logic                      hdr4_q_o,
  output logic                      addr2_q_o,
  output logic [DW-1:0]             carry_q_o
);
  // upper header dwords are needed after the command port has moved on
  for (genvar g = 0; g < HI_CNT; g++) begin : g_hdr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         hdr_q_o[g] <= '0;
      else if (cmd_take_i) hdr_q_o[g] <= cmd_hdr_hi_i[g*DW +: DW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr4_q_o  <= 1'b0;
      addr2_q_o <= 1'b0;
    end else if (cmd_take_i) begin
      hdr4_q_o  <= cmd_hdr4_i;
      addr2_q_o <= cmd_addr2_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           carry_q_o <= '0;
    else if (carry_take_i) carry_q_o <= carry_d_i;
  end
endmodule

// File: rtl/tlp_pack_beat.sv
module tlp_pack_beat
  import tlp_pack_pkg::*;
#(
  parameter int DW = 32
) (
  input  pack_st_e          st_i,
  input  logic [2*DW-1:0]   hdr_lo_i,
  input  logic [1:0][DW-1:0] hdr_q_i,
  input  logic              hdr4_q_i,
  input  logic [DW-1:0]     carry_i,
  input  logic [2*DW-1:0]   pld_i,
  input  logic              last_lo_i,
  output logic [2*DW-1:0]   beat_o
);
  logic [DW-1:0] lo, hi, p_lo, p_hi;

  assign p_lo = pld_i[DW-1:0];
  assign p_hi = pld_i[2*DW-1:DW];

  always_comb begin
    lo = '0;
    hi = '0;
    unique case (st_i)
      ST_H0: begin
        lo = hdr_lo_i[DW-1:0];
        hi = hdr_lo_i[2*DW-1:DW];
      end
      ST_H1: begin
        lo = hdr_q_i[0];
        hi = hdr4_q_i ? hdr_q_i[1] : '0;
      end
      ST_ODD: begin
        lo = hdr4_q_i ? '0 : hdr_q_i[0];
        hi = p_lo;
      end
      ST_EVEN: begin
        lo = p_lo;
        hi = last_lo_i ? '0 : p_hi;
      end
      ST_SHIFT: begin
        lo = carry_i;
        hi = p_lo;
      end
      ST_TAIL: lo = carry_i;
      default: ;
    endcase
  end

  assign beat_o = {hi, lo};
endmodule

// File: rtl/tlp_packer.sv
module tlp_packer
  import tlp_pack_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [4*DW-1:0]  cmd_hdr_i,
  input  logic             cmd_hdr4_i,
  input  logic             cmd_addr2_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic             pld_valid_i,
  output logic             pld_ready_o,
  input  logic [2*DW-1:0]  pld_data_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [2*DW-1:0]  tx_data_o,
  output logic             tx_sop_o,
  output logic             tx_eop_o
);
  localparam int BEAT_W = 2 * DW;

  pack_st_e           st;
  logic               addr2_q, hdr4_q, last_lo, cmd_take, carry_take;
  logic [1:0][DW-1:0] hdr_q;
  logic [DW-1:0]      carry_q;

  tlp_pack_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_hdr4_i   (cmd_hdr4_i),
    .cmd_addr2_i  (cmd_addr2_i),
    .cmd_len_i    (cmd_len_i),
    .addr2_q_i    (addr2_q),
    .pld_valid_i  (pld_valid_i),
    .tx_ready_i   (tx_ready_i),
    .st_o         (st),
    .cmd_ready_o  (cmd_ready_o),
    .pld_ready_o  (pld_ready_o),
    .tx_valid_o   (tx_valid_o),
    .tx_sop_o     (tx_sop_o),
    .tx_eop_o     (tx_eop_o),
    .last_lo_o    (last_lo),
    .cmd_take_o   (cmd_take),
    .carry_take_o (carry_take)
  );

  tlp_pack_store #(.DW(DW), .HI_CNT(2)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_take_i   (cmd_take),
    .cmd_hdr_hi_i (cmd_hdr_i[4*DW-1:2*DW]),
    .cmd_hdr4_i   (cmd_hdr4_i),
    .cmd_addr2_i  (cmd_addr2_i),
    .carry_take_i (carry_take),
    .carry_d_i    (pld_data_i[BEAT_W-1:DW]),
    .hdr_q_o      (hdr_q),
    .hdr4_q_o     (hdr4_q),
    .addr2_q_o    (addr2_q),
    .carry_q_o    (carry_q)
  );

  tlp_pack_beat #(.DW(DW)) u_beat (
    .st_i      (st),
    .hdr_lo_i  (cmd_hdr_i[2*DW-1:0]),
    .hdr_q_i   (hdr_q),
    .hdr4_q_i  (hdr4_q),
    .carry_i   (carry_q),
    .pld_i     (pld_data_i),
    .last_lo_i (last_lo),
    .beat_o    (tx_data_o)
  );
endmodule

// File: rtl/tlp_pack_chk.sv
module tlp_pack_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic          cmd_ready_o,
  input logic          pld_ready_o,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [2*DW-1:0] tx_data_o,
  input logic          tx_sop_o,
  input logic          tx_eop_o
);
  // R8: stalled beat is held (sources assumed to hold their transfers)
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=>
      (tx_valid_o && $stable(tx_data_o) && $stable(tx_sop_o) && $stable(tx_eop_o)));

  // R8: nothing taken from either source under backpressure
  p_no_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ready_i |-> (!cmd_ready_o && !pld_ready_o));

  // R1: a first beat is never also the last
  p_sop_not_eop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_sop_o) |-> !tx_eop_o);

  // R1: command accepted together with the SOP beat
  p_cmd_at_sop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |-> (tx_valid_o && tx_sop_o && tx_ready_i));

  // R1: no SOP after a non-final beat
  p_mid_no_sop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && !tx_eop_o) |=> !tx_sop_o);

  // R9: after EOP the next beat is a SOP
  p_next_sop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && tx_eop_o) |=> (tx_sop_o && (tx_valid_o == cmd_valid_i)));
endmodule

bind tlp_packer tlp_pack_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .pld_ready_o (pld_ready_o),
  .tx_valid_o  (tx_valid_o),
  .tx_ready_i  (tx_ready_i),
  .tx_data_o   (tx_data_o),
  .tx_sop_o    (tx_sop_o),
  .tx_eop_o    (tx_eop_o)
);

// File: tb/tlp_packer_tb.sv
module tlp_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 32;
  localparam int LEN_W      = 10;
  localparam int RUN_LIMIT  = 4000;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             cmd_valid_i = 1'b0, cmd_ready_o;
  logic [4*DW-1:0]  cmd_hdr_i = '0;
  logic             cmd_hdr4_i = 1'b0, cmd_addr2_i = 1'b0;
  logic [LEN_W-1:0] cmd_len_i = '0;
  logic             pld_valid_i = 1'b0, pld_ready_o;
  logic [2*DW-1:0]  pld_data_i = '0;
  logic             tx_valid_o, tx_ready_i = 1'b0;
  logic [2*DW-1:0]  tx_data_o;
  logic             tx_sop_o, tx_eop_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlp_packer #(.DW(DW), .LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_hdr_i(cmd_hdr_i),
    .cmd_hdr4_i(cmd_hdr4_i), .cmd_addr2_i(cmd_addr2_i), .cmd_len_i(cmd_len_i),
    .pld_valid_i(pld_valid_i), .pld_ready_o(pld_ready_o), .pld_data_i(pld_data_i),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
    .tx_sop_o(tx_sop_o), .tx_eop_o(tx_eop_o)
  );

  int n_checks = 0, n_errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // packet list for one run
  int               npkt;
  bit               p_hdr4 [4];
  bit               p_a2   [4];
  logic [LEN_W-1:0] p_len  [4];

  function automatic int n_of(int k);
    return (p_len[k] == '0) ? 1024 : int'(p_len[k]);
  endfunction
  function automatic logic [31:0] hdr_dw(int k, int j);
    return 32'h4800_0000 | (k << 8) | j;
  endfunction
  function automatic logic [31:0] pay_dw(int k, int i);
    return (i < n_of(k)) ? (32'hA000_0000 | (k << 20) | i) : 32'hDEAD_BEEF;
  endfunction
  function automatic int p0_of(int k);
    int h = p_hdr4[k] ? 4 : 3;
    return ((h % 2) == int'(p_a2[k])) ? h : h + 1;
  endfunction
  function automatic int nbeats(int k);
    return (p0_of(k) + n_of(k) + 1) / 2;
  endfunction
  function automatic int pbeats(int k);
    return (n_of(k) + 1) / 2;
  endfunction
  function automatic logic [31:0] exp_dw(int k, int pos);
    int h  = p_hdr4[k] ? 4 : 3;
    int p0 = p0_of(k);
    if (pos < h) return hdr_dw(k, pos);
    if (pos < p0) return 32'h0;
    if (pos < p0 + n_of(k)) return pay_dw(k, pos - p0);
    return 32'h0;
  endfunction

  task automatic run_seq(input string req, input bit stall, input bit gaps);
    int cmd_k = 0, pld_k = 0, pld_j = 0, mon_k = 0, mon_b = 0;
    int pld_taken = 0, pld_need = 0, cyc = 0;
    bit pend = 0, prev_stall = 0, prev_eop = 0;
    logic [63:0] s_data;
    logic s_sop, s_eop;
    for (int k = 0; k < npkt; k++) pld_need += pbeats(k);
    while (mon_k < npkt && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cmd_valid_i = (cmd_k < npkt);
      if (cmd_k < npkt) begin
        cmd_hdr_i   = {hdr_dw(cmd_k, 3), hdr_dw(cmd_k, 2), hdr_dw(cmd_k, 1), hdr_dw(cmd_k, 0)};
        cmd_hdr4_i  = p_hdr4[cmd_k];
        cmd_addr2_i = p_a2[cmd_k];
        cmd_len_i   = p_len[cmd_k];
      end
      if (!pend) begin
        pld_valid_i = (pld_k < npkt) && (!gaps || (cyc % 3) != 2);
        if (pld_k < npkt) pld_data_i = {pay_dw(pld_k, 2*pld_j+1), pay_dw(pld_k, 2*pld_j)};
      end
      tx_ready_i = !stall || !((cyc % 5) == 1 || (cyc % 5) == 3);
      #1;
      if (prev_stall) begin
        check(tx_valid_o && tx_data_o == s_data && tx_sop_o == s_sop && tx_eop_o == s_eop,
              "R8", "stalled beat held", tx_data_o, s_data);
      end
      if (!tx_ready_i)
        check(!cmd_ready_o && !pld_ready_o, "R8", "ready while stalled",
              {62'b0, cmd_ready_o, pld_ready_o}, 64'h0);
      if (prev_eop && mon_k < npkt)
        check(tx_valid_o && tx_sop_o, "R9", "back-to-back SOP",
              {62'b0, tx_valid_o, tx_sop_o}, 64'h3);
      prev_eop = 0;
      if (tx_valid_o && tx_ready_i) begin
        int nb = nbeats(mon_k);
        check(tx_data_o == {exp_dw(mon_k, 2*mon_b+1), exp_dw(mon_k, 2*mon_b)}, req, "beat data",
              tx_data_o, {exp_dw(mon_k, 2*mon_b+1), exp_dw(mon_k, 2*mon_b)});
        check(tx_sop_o == (mon_b == 0), "R1", "sop flag", 64'(tx_sop_o), 64'(mon_b == 0));
        check(tx_eop_o == (mon_b == nb - 1), "R6", "eop flag", 64'(tx_eop_o), 64'(mon_b == nb - 1));
        if (mon_b == nb - 1) begin
          mon_k++;
          mon_b = 0;
          prev_eop = 1;
        end else mon_b++;
      end
      prev_stall = tx_valid_o && !tx_ready_i;
      s_data = tx_data_o;
      s_sop  = tx_sop_o;
      s_eop  = tx_eop_o;
      if (cmd_valid_i && cmd_ready_o) cmd_k++;
      if (pld_valid_i && pld_ready_o) begin
        pld_taken++;
        pend = 0;
        pld_j++;
        if (pld_j == pbeats(pld_k)) begin
          pld_k++;
          pld_j = 0;
        end
      end else pend = pld_valid_i;
      cyc++;
    end
    if (cyc >= RUN_LIMIT) check(1'b0, req, "watchdog expired", 64'(cyc), 64'(RUN_LIMIT));
    check(pld_taken == pld_need, "R11", "payload transfers taken", 64'(pld_taken), 64'(pld_need));
    @(negedge clk);
    cmd_valid_i = 0;
    pld_valid_i = 0;
    tx_ready_i  = 1;
  endtask

  task automatic set_pkt(input int k, input bit h4, input bit a2, input int len);
    p_hdr4[k] = h4;
    p_a2[k]   = a2;
    p_len[k]  = LEN_W'(len);
  endtask

  task automatic t_reset();
    @(negedge clk);
    tx_ready_i = 1;
    #1;
    check(!tx_valid_o, "R10", "tx_valid after reset", 64'(tx_valid_o), 64'h0);
    check(!pld_ready_o, "R10", "pld_ready after reset", 64'(pld_ready_o), 64'h0);
    check(tx_sop_o, "R10", "idle state presents SOP slot", 64'(tx_sop_o), 64'h1);
  endtask

  task automatic t_h3_unaligned();
    npkt = 3;
    set_pkt(0, 0, 1, 1); set_pkt(1, 0, 1, 2); set_pkt(2, 0, 1, 5);
    run_seq("R2", 0, 0);
  endtask

  task automatic t_h3_aligned();
    npkt = 3;
    set_pkt(0, 0, 0, 1); set_pkt(1, 0, 0, 4); set_pkt(2, 0, 0, 3);
    run_seq("R3", 0, 0);
  endtask

  task automatic t_h4_aligned();
    npkt = 2;
    set_pkt(0, 1, 0, 3); set_pkt(1, 1, 0, 2);
    run_seq("R4", 0, 0);
  endtask

  task automatic t_h4_unaligned();
    npkt = 3;
    set_pkt(0, 1, 1, 1); set_pkt(1, 1, 1, 6); set_pkt(2, 1, 1, 7);
    run_seq("R5", 0, 0);
  endtask

  task automatic t_len_max();
    npkt = 2;
    set_pkt(0, 0, 0, 0); set_pkt(1, 1, 1, 0);
    run_seq("R7", 0, 0);
  endtask

  task automatic t_stall();
    npkt = 4;
    set_pkt(0, 0, 1, 4); set_pkt(1, 1, 1, 3); set_pkt(2, 0, 0, 5); set_pkt(3, 1, 0, 1);
    run_seq("R8", 1, 1);
  endtask

  task automatic t_back_to_back();
    npkt = 4;
    set_pkt(0, 1, 0, 1); set_pkt(1, 0, 1, 1); set_pkt(2, 1, 1, 2); set_pkt(3, 0, 0, 2);
    run_seq("R9", 0, 0);
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_h3_unaligned();
    t_h3_aligned();
    t_h4_aligned();
    t_h4_unaligned();
    t_len_max();
    t_stall();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule